// File: doc/BRIEF.md
# Rotate Instruction Decoder with Cycle Costing

This block decodes the rotate-left and rotate-right instruction group of a 16-bit accumulator processor core with a banked 24-bit address space. For each opcode it presented, it reports four things. It says whether the opcode belongs to the group and which way the rotate goes. It says whether the operand is the accumulator or a memory location. It gives the number of operand bytes the instruction takes, the 24-bit effective address of the memory target, and the total number of clock cycles the instruction costs.

The width flags of the core steer the result. The data-width flag, when set, selects 8-bit data. When clear it selects 16-bit data, and every memory form then costs one more cycle. The index-width flag, when set, limits the index register to its low byte for the indexed direct-page form. A direct-page base that is not aligned to a 256-byte page adds one cycle to the direct-page forms. Results are registered once, so they appear one clock after the inputs are sampled. The bus sequencing and the rotate arithmetic belong to other blocks.

Top module: `rot_decode`

## Requirements
- R1: Opcodes 0x2A, 0x2E, 0x3E, 0x26 and 0x36 give `handled`=1 and `rot_right`=0. Their targets are, in that order: the accumulator, absolute, absolute indexed, direct page, and direct page indexed.
- R2: Opcodes 0x6A, 0x6E, 0x7E, 0x66 and 0x76 give `handled`=1 and `rot_right`=1, with the same target list in the same order as R1.
- R3: Every other opcode gives `handled`=0. After reset, `handled` and `cycles` read 0 until the first decode completes.
- R4: Accumulator forms give `to_accum`=1, `oper_len`=0 and `cycles`=2 whatever the flags hold. Memory forms give `to_accum`=0.
- R5: Absolute forms cost 6 cycles with `m_flag`=1 and 7 with `m_flag`=0. Absolute indexed forms cost 7 and 8. Neither depends on the direct-page base.
- R6: Direct-page forms cost 5 cycles with `m_flag`=1 and 6 with `m_flag`=0. Direct-page indexed forms cost 6 and 7, before the penalty of R7.
- R7: Direct-page and direct-page indexed forms cost one extra cycle whenever `dp_base[7:0]` is non-zero. This penalty adds to the extra cycle of R6 when `m_flag`=0.
- R8: For absolute forms, `eff_addr` = {`bank`, `opnd_hi`, `opnd_lo`}.
- R9: For absolute indexed forms, `eff_addr` = {`bank`, ({`opnd_hi`,`opnd_lo`} + `index`) mod 2^16`}`, so the sum never carries into the bank field.
- R10: For direct-page forms, `eff_addr` = {8'h00, (`dp_base` + `opnd_lo`) mod 2^16`}`.
- R11: For direct-page indexed forms, the direct-page sum of R10 also adds the index. With `x_flag`=1 only `index[7:0]` is added; with `x_flag`=0 all 16 bits are added.
- R12: `oper_len` is 2 for absolute and absolute indexed forms and 1 for direct-page and direct-page indexed forms.
- R13: Every output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 8 | Opcode under decode |
| m_flag | input | 1 | Data-width flag, 1 = 8-bit data |
| x_flag | input | 1 | Index-width flag, 1 = 8-bit index |
| dp_base | input | 16 | Direct-page base register |
| bank | input | 8 | Data bank register |
| index | input | 16 | Index register |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| handled | output | 1 | Opcode belongs to the rotate group |
| rot_right | output | 1 | 1 = rotate right, 0 = rotate left |
| to_accum | output | 1 | Target is the accumulator |
| oper_len | output | 2 | Operand bytes consumed |
| eff_addr | output | 24 | Effective address of a memory target |
| cycles | output | 4 | Total instruction cycle count |

## Verification
The cycle count can take the 16-bit width cycle and the page-misalignment cycle in the same decode. When they coincide on a direct-page indexed form the count reaches its peak of 8. The bench sweeps every opcode against all four flag combinations. It does this both with an aligned and with a misaligned direct-page base, so both extra cycles fall together on every direct-page form. Each count is compared against the sum worked out from R6 and R7. In the same sweep the operands and index sit near the top of the 16-bit range, so the indexed sums wrap exactly when the costs are also at their highest. Each address is checked against a modulo-2^16 sum with the bank field attached or forced to zero.

// File: rtl/rot_dec_pkg.sv
package rot_dec_pkg;

   typedef enum logic [2:0] {
      AM_ACC  = 3'd0,
      AM_ABS  = 3'd1,
      AM_ABSX = 3'd2,
      AM_DP   = 3'd3,
      AM_DPX  = 3'd4
   } amode_t;

   typedef struct packed {
      logic   hit;
      logic   right;
      amode_t mode;
   } dec_t;

   // base cycle costs with 8-bit data
   localparam int CYC_ACC  = 2;
   localparam int CYC_ABS  = 6;
   localparam int CYC_ABSX = 7;
   localparam int CYC_DP   = 5;
   localparam int CYC_DPX  = 6;

endpackage

// File: rtl/rot_opcode_map.sv
module rot_opcode_map
   import rot_dec_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] opcode,
   output dec_t              dec
);

   // group members share bit7=0 and bit5=1; bit6 picks direction,
   // bit4 picks the indexed variant, the low nibble picks the family
   logic in_group;
   assign in_group = !opcode[7] && opcode[5];

   always_comb begin
      dec       = '0;
      dec.mode  = AM_ACC;
      dec.right = opcode[6];
      if (in_group) begin
         case (opcode[3:0])
            4'hA: begin
               dec.hit  = !opcode[4];
               dec.mode = AM_ACC;
            end
            4'hE: begin
               dec.hit  = 1'b1;
               dec.mode = opcode[4] ? AM_ABSX : AM_ABS;
            end
            4'h6: begin
               dec.hit  = 1'b1;
               dec.mode = opcode[4] ? AM_DPX : AM_DP;
            end
            default: dec.hit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/rot_addr_gen.sv
module rot_addr_gen
   import rot_dec_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int BANK_W = 8,
   localparam int ADDR_W = BANK_W + WORD_W
) (
   input  amode_t            mode,
   input  logic              idx_narrow,
   input  logic [WORD_W-1:0] dp_base,
   input  logic [BANK_W-1:0] bank,
   input  logic [WORD_W-1:0] index,
   input  logic [BYTE_W-1:0] opnd_lo,
   input  logic [BYTE_W-1:0] opnd_hi,
   output logic [ADDR_W-1:0] ea
);

   logic [WORD_W-1:0] opnd_word;
   logic [WORD_W-1:0] idx_eff;
   logic [WORD_W-1:0] abs_off;
   logic [WORD_W-1:0] dp_off;
   logic [WORD_W-1:0] dp_idx;

   assign opnd_word = {opnd_hi, opnd_lo};
   assign idx_eff   = idx_narrow ? WORD_W'(index[BYTE_W-1:0]) : index;

   // absolute indexed wraps inside the word before the bank is attached
   assign abs_off = (mode == AM_ABSX) ? opnd_word + index : opnd_word;
   assign dp_idx  = (mode == AM_DPX) ? idx_eff : '0;
   assign dp_off  = dp_base + WORD_W'(opnd_lo) + dp_idx;

   always_comb begin
      case (mode)
         AM_ABS, AM_ABSX: ea = {bank, abs_off};
         AM_DP, AM_DPX:   ea = {{BANK_W{1'b0}}, dp_off};
         default:         ea = '0;
      endcase
   end

endmodule

// File: rtl/rot_cycle_calc.sv
module rot_cycle_calc
   import rot_dec_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int CYC_W  = 4
) (
   input  amode_t            mode,
   input  logic              wide_data,
   input  logic [WORD_W-1:0] dp_base,
   output logic [CYC_W-1:0]  cycles,
   output logic [1:0]        oper_len
);

   logic             misaligned;
   logic [CYC_W-1:0] base;
   logic [CYC_W-1:0] width_add;
   logic [CYC_W-1:0] page_add;

   assign misaligned = |dp_base[BYTE_W-1:0];

   always_comb begin
      base      = '0;
      width_add = '0;
      page_add  = '0;
      oper_len  = 2'd0;
      case (mode)
         AM_ACC: base = CYC_W'(CYC_ACC);
         AM_ABS: begin
            base      = CYC_W'(CYC_ABS);
            width_add = CYC_W'(wide_data);
            oper_len  = 2'd2;
         end
         AM_ABSX: begin
            base      = CYC_W'(CYC_ABSX);
            width_add = CYC_W'(wide_data);
            oper_len  = 2'd2;
         end
         AM_DP: begin
            base      = CYC_W'(CYC_DP);
            width_add = CYC_W'(wide_data);
            page_add  = CYC_W'(misaligned);
            oper_len  = 2'd1;
         end
         AM_DPX: begin
            base      = CYC_W'(CYC_DPX);
            width_add = CYC_W'(wide_data);
            page_add  = CYC_W'(misaligned);
            oper_len  = 2'd1;
         end
         default: base = '0;
      endcase
      cycles = base + width_add + page_add;
   end

endmodule

// File: rtl/rot_decode.sv
module rot_decode
   import rot_dec_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int WORD_W  = 16,
   parameter int BANK_W  = 8,
   parameter int CYC_W   = 4,
   parameter bit REG_OUT = 1'b1,
   localparam int ADDR_W = BANK_W + WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] opcode,
   input  logic              m_flag,
   input  logic              x_flag,
   input  logic [WORD_W-1:0] dp_base,
   input  logic [BANK_W-1:0] bank,
   input  logic [WORD_W-1:0] index,
   input  logic [BYTE_W-1:0] opnd_lo,
   input  logic [BYTE_W-1:0] opnd_hi,
   output logic              handled,
   output logic              rot_right,
   output logic              to_accum,
   output logic [1:0]        oper_len,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [CYC_W-1:0]  cycles
);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("rot_decode: opcode map assumes BYTE_W of 8");
   end
   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("rot_decode: WORD_W must be twice BYTE_W");
   end
   if (CYC_W < 4) begin : g_bad_cyc
      $error("rot_decode: CYC_W too narrow for a count of 8");
   end

   dec_t              dec;
   logic [ADDR_W-1:0] ea_c;
   logic [CYC_W-1:0]  cyc_c;
   logic [1:0]        len_c;

   rot_opcode_map #(.BYTE_W(BYTE_W)) u_map (
      .opcode (opcode),
      .dec    (dec)
   );

   rot_addr_gen #(
      .BYTE_W(BYTE_W), .WORD_W(WORD_W), .BANK_W(BANK_W)
   ) u_addr (
      .mode       (dec.mode),
      .idx_narrow (x_flag),
      .dp_base    (dp_base),
      .bank       (bank),
      .index      (index),
      .opnd_lo    (opnd_lo),
      .opnd_hi    (opnd_hi),
      .ea         (ea_c)
   );

   rot_cycle_calc #(
      .BYTE_W(BYTE_W), .WORD_W(WORD_W), .CYC_W(CYC_W)
   ) u_cyc (
      .mode      (dec.mode),
      .wide_data (!m_flag),
      .dp_base   (dp_base),
      .cycles    (cyc_c),
      .oper_len  (len_c)
   );

   // unhandled opcodes present all-zero outputs
   logic              hit_n;
   logic              right_n;
   logic              acc_n;
   logic [1:0]        len_n;
   logic [ADDR_W-1:0] ea_n;
   logic [CYC_W-1:0]  cyc_n;

   assign hit_n   = dec.hit;
   assign right_n = dec.hit & dec.right;
   assign acc_n   = dec.hit & (dec.mode == AM_ACC);
   assign len_n   = dec.hit ? len_c : 2'd0;
   assign ea_n    = dec.hit ? ea_c : '0;
   assign cyc_n   = dec.hit ? cyc_c : '0;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            handled   <= 1'b0;
            rot_right <= 1'b0;
            to_accum  <= 1'b0;
            oper_len  <= 2'd0;
            eff_addr  <= '0;
            cycles    <= '0;
         end else begin
            handled   <= hit_n;
            rot_right <= right_n;
            to_accum  <= acc_n;
            oper_len  <= len_n;
            eff_addr  <= ea_n;
            cycles    <= cyc_n;
         end
      end
   end else begin : g_comb
      assign handled   = hit_n;
      assign rot_right = right_n;
      assign to_accum  = acc_n;
      assign oper_len  = len_n;
      assign eff_addr  = ea_n;
      assign cycles    = cyc_n;
   end

endmodule

// File: rtl/rot_decode_chk.sv
module rot_decode_chk #(
   parameter int BYTE_W  = 8,
   parameter int BANK_W  = 8,
   parameter int ADDR_W  = 24,
   parameter int CYC_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] opcode,
   input logic [BANK_W-1:0] bank,
   input logic              handled,
   input logic              to_accum,
   input logic [1:0]        oper_len,
   input logic [ADDR_W-1:0] eff_addr,
   input logic [CYC_W-1:0]  cycles
);

   logic past_ok;
   logic is_rot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign is_rot = opcode inside {8'h2A, 8'h2E, 8'h3E, 8'h26, 8'h36,
                                  8'h6A, 8'h6E, 8'h7E, 8'h66, 8'h76};

   // R4: accumulator target costs two cycles and no operand
   a_r4_accum_cost: assert property (@(posedge clk) disable iff (!rst_n)
      handled && to_accum |-> cycles == CYC_W'(2) && oper_len == 2'd0);

   // R10: direct-page targets stay in bank zero
   a_r10_dp_bank0: assert property (@(posedge clk) disable iff (!rst_n)
      handled && oper_len == 2'd1 |-> eff_addr[ADDR_W-1:ADDR_W-BANK_W] == '0);

   // R5: two-byte forms cost 6 to 8 cycles
   a_r5_abs_range: assert property (@(posedge clk) disable iff (!rst_n)
      handled && oper_len == 2'd2 |-> cycles >= CYC_W'(6) && cycles <= CYC_W'(8));

   // R6: one-byte forms cost 5 to 8 cycles
   a_r6_dp_range: assert property (@(posedge clk) disable iff (!rst_n)
      handled && oper_len == 2'd1 |-> cycles >= CYC_W'(5) && cycles <= CYC_W'(8));

   // R12: memory forms always take operand bytes
   a_r12_mem_len: assert property (@(posedge clk) disable iff (!rst_n)
      handled && !to_accum |-> oper_len != 2'd0);

   if (REG_OUT) begin : g_lat1
      // R3, R13: membership appears one clock after the opcode
      a_r3_membership: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> handled == $past(is_rot));
      // R8: absolute address carries the previous bank
      a_r8_bank: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && handled && oper_len == 2'd2 |->
            eff_addr[ADDR_W-1:ADDR_W-BANK_W] == $past(bank));
   end else begin : g_lat0
      a_r3_membership: assert property (@(posedge clk) disable iff (!rst_n)
         handled == is_rot);
      a_r8_bank: assert property (@(posedge clk) disable iff (!rst_n)
         handled && oper_len == 2'd2 |-> eff_addr[ADDR_W-1:ADDR_W-BANK_W] == bank);
   end

endmodule

bind rot_decode rot_decode_chk #(
   .BYTE_W(BYTE_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
   .CYC_W(CYC_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .opcode   (opcode),
   .bank     (bank),
   .handled  (handled),
   .to_accum (to_accum),
   .oper_len (oper_len),
   .eff_addr (eff_addr),
   .cycles   (cycles)
);

// File: tb/rot_decode_test.sv
module rot_decode_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  opcode = '0;
   logic        m_flag = 1'b1;
   logic        x_flag = 1'b1;
   logic [15:0] dp_base = '0;
   logic [7:0]  bank = '0;
   logic [15:0] index = '0;
   logic [7:0]  opnd_lo = '0;
   logic [7:0]  opnd_hi = '0;
   logic        handled;
   logic        rot_right;
   logic        to_accum;
   logic [1:0]  oper_len;
   logic [23:0] eff_addr;
   logic [3:0]  cycles;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   rot_decode uut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .m_flag(m_flag),
      .x_flag(x_flag), .dp_base(dp_base), .bank(bank), .index(index),
      .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .handled(handled),
      .rot_right(rot_right), .to_accum(to_accum), .oper_len(oper_len),
      .eff_addr(eff_addr), .cycles(cycles)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (op %02h m %0b x %0b d %04h)",
                  tag, act, exp, opcode, m_flag, x_flag, dp_base);
      end
   endtask

   // inputs are driven at a negative edge; results are read at the next one
   task automatic apply_and_check();
      bit          rot, right, acc;
      int          fam;   // 0 acc, 1 abs, 2 absx, 3 dp, 4 dpx
      int          cyc, len;
      logic [15:0] w, ix;
      logic [23:0] ea;
      rot   = 1'b0;
      right = 1'b0;
      fam   = 0;
      case (opcode)
         8'h2A: begin rot = 1; fam = 0; end
         8'h2E: begin rot = 1; fam = 1; end
         8'h3E: begin rot = 1; fam = 2; end
         8'h26: begin rot = 1; fam = 3; end
         8'h36: begin rot = 1; fam = 4; end
         8'h6A: begin rot = 1; right = 1; fam = 0; end
         8'h6E: begin rot = 1; right = 1; fam = 1; end
         8'h7E: begin rot = 1; right = 1; fam = 2; end
         8'h66: begin rot = 1; right = 1; fam = 3; end
         8'h76: begin rot = 1; right = 1; fam = 4; end
         default: rot = 0;
      endcase
      acc = (fam == 0);
      case (fam)
         0: begin cyc = 2; len = 0; end
         1: begin cyc = 6 + int'(!m_flag); len = 2; end
         2: begin cyc = 7 + int'(!m_flag); len = 2; end
         3: begin cyc = 5 + int'(!m_flag) + int'(dp_base[7:0] != 0); len = 1; end
         default: begin cyc = 6 + int'(!m_flag) + int'(dp_base[7:0] != 0); len = 1; end
      endcase
      ix = x_flag ? {8'h00, index[7:0]} : index;
      case (fam)
         1: ea = {bank, opnd_hi, opnd_lo};
         2: begin w = {opnd_hi, opnd_lo} + index; ea = {bank, w}; end
         3: begin w = dp_base + {8'h00, opnd_lo}; ea = {8'h00, w}; end
         default: begin w = dp_base + {8'h00, opnd_lo} + ix; ea = {8'h00, w}; end
      endcase
      @(posedge clk);
      @(negedge clk);
      if (!rot) begin
         chk("R3 handled", handled, 0);
      end else begin
         chk(right ? "R2 handled" : "R1 handled", handled, 1);
         chk(right ? "R2 direction" : "R1 direction", rot_right, right);
         chk("R4 to_accum", to_accum, acc);
         chk(acc ? "R4 oper_len" : "R12 oper_len", oper_len, len);
         case (fam)
            0: chk("R4 cycles", cycles, cyc);
            1, 2: chk("R5 cycles", cycles, cyc);
            default: chk("R6 R7 cycles", cycles, cyc);
         endcase
         case (fam)
            1: chk("R8 address", eff_addr, ea);
            2: chk("R9 address", eff_addr, ea);
            3: chk("R10 address", eff_addr, ea);
            4: chk("R11 address", eff_addr, ea);
            default: ;
         endcase
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R3: reset state
      chk("R3 reset handled", handled, 0);
      chk("R3 reset cycles", cycles, 0);
      rst_n = 1'b1;

      // near-exhaustive sweep: every opcode, both flags, aligned/misaligned base
      for (int op = 0; op < 256; op++) begin
         for (int k = 0; k < 8; k++) begin
            opcode  = 8'(op);
            m_flag  = k[0];
            x_flag  = k[1];
            dp_base = k[2] ? 16'hFF37 : 16'hFF00;
            bank    = 8'(op * 7 + k);
            index   = 16'hFE80 ^ 16'(op * 293 + k * 11);
            opnd_lo = 8'(op * 37 + k);
            opnd_hi = 8'hF0 | 8'(k);
            apply_and_check();
         end
      end

      // R9: indexed absolute wraps inside the word
      opcode = 8'h3E; m_flag = 1; x_flag = 0; bank = 8'h5A;
      opnd_hi = 8'hFF; opnd_lo = 8'hFF; index = 16'h0002;
      apply_and_check();
      chk("R9 wrap value", eff_addr, 24'h5A0001);

      // R10: direct-page sum wraps and keeps bank zero
      opcode = 8'h66; dp_base = 16'hFFF0; opnd_lo = 8'h20; bank = 8'hC3;
      apply_and_check();
      chk("R10 wrap value", eff_addr, 24'h000010);

      // R11: narrow vs wide index on direct page indexed
      opcode = 8'h36; dp_base = 16'h0100; opnd_lo = 8'h01; index = 16'h1280;
      x_flag = 1;
      apply_and_check();
      chk("R11 narrow index", eff_addr, 24'h000181);
      x_flag = 0;
      apply_and_check();
      chk("R11 wide index", eff_addr, 24'h001381);

      // R7: both extra cycles on direct page indexed give 8; none on absolute
      opcode = 8'h76; m_flag = 0; dp_base = 16'h00FF;
      apply_and_check();
      chk("R7 peak cycles", cycles, 8);
      opcode = 8'h6E;
      apply_and_check();
      chk("R7 absolute unaffected", cycles, 7);

      // R13: output follows the previous edge's opcode
      opcode = 8'h2A;
      @(posedge clk);
      @(negedge clk);
      opcode = 8'h00;
      #1;
      chk("R13 latency hold", handled, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R13 latency update", handled, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule